// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block models a synchronous static memory with a double-data-rate data port. Every transfer is a fixed burst of four words, moved over two periods of the main clock. The design runs from a single beat clock at twice the main clock rate. An internal phase flag marks which beats are rising halves and which are falling halves of the main clock. A command is captured only on a rising-half beat. The command is an active-low load strobe, the address and a read/write direction bit.

Write words are taken one per beat, starting on the beat that carries the load. Each word is merged into storage under active-low write selects, one per 9-bit lane. Read words leave the core one main-clock period (two beats) after the load, one word per beat. An output-enable flag is high only while a read beat is being presented, so an enclosing level can turn it into a tristate driver. The two lowest address bits seed a linear counter that wraps inside the aligned group of four words. A load that arrives while a burst is still running is discarded and sets a sticky error flag.

Top module: `ddr_burst4_sram`

## Requirements
- R1: While reset is high and on the first beat after it, rdata_oe is 0, rdata is 0, cmd_err is 0 and rise_phase is 1.
- R2: rise_phase alternates on every beat once reset is released.
- R3: load_n is acted on only at a beat edge where rise_phase is 1. A low load_n at a falling-half edge writes nothing, starts no read and leaves cmd_err at 0.
- R4: At an accepted load, rd_nwr equal to 1 selects a read and rd_nwr equal to 0 selects a write.
- R5: A write accepted at edge t stores the wdata presented at edges t, t+1, t+2 and t+3. The word at edge t+k goes to the address whose upper bits equal addr and whose two low bits are (addr[1:0]+k) mod 4.
- R6: For each beat, wsel_n[i] low writes lane i, which is bits [9i+8:9i] of a 36-bit word. wsel_n[i] high leaves that lane's stored bits unchanged.
- R7: For a read accepted at edge t, rdata holds word k of the burst from edge t+2+k until the next edge. Word k comes from the same linear-wrap address as in R5.
- R8: rdata_oe is 1 exactly during those four read beats. Whenever rdata_oe is 0, rdata is 0.
- R9: A load at a rising-half edge two beats into a running burst is discarded. The running burst completes unchanged, and cmd_err goes to 1 and stays there until reset.
- R10: Reads accepted at edges t and t+4 give eight consecutive read beats with rdata_oe held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the main clock rate |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low command strobe |
| rd_nwr | input | 1 | Direction: 1 read, 0 write |
| addr | input | ADDR_W | Word address of the burst start |
| wdata | input | DATA_W | Write word for the current beat |
| wsel_n | input | LANES | Active-low lane write selects for the current beat |
| rise_phase | output | 1 | High when the coming edge is a rising-half beat |
| rdata | output | DATA_W | Read word, zero when not enabled |
| rdata_oe | output | 1 | Read output enable |
| cmd_err | output | 1 | Sticky flag for a discarded overlapping load |

## Verification
The bench drives inputs and samples outputs on the falling clock edge, so the values it sees reflect every register updated at the preceding rising edge. Call the edge that takes a load edge t. A write beat k is consumed at edge t+k. Read word k is therefore sampled half a beat after edge t+2+k. rdata_oe is also checked low at the two samples before that window and at the one sample after it. cmd_err is checked half a beat after the clashing edge t+2. For a discarded read, the bench watches rdata_oe over the samples where the dropped read's data would have appeared.

// File: rtl/ddr_burst4_pkg.sv
package ddr_burst4_pkg;

    localparam int BURST_LEN = 4;

    typedef logic [1:0] beat_idx_t;

    // State of the burst in flight
    typedef struct packed {
        logic      busy;
        logic      rd;
        beat_idx_t cnt;
        beat_idx_t lo;
    } burst_st_t;

    // Linear wrap of the two low address bits inside a group of four
    function automatic beat_idx_t wrap_lo(beat_idx_t lo, beat_idx_t k);
        return beat_idx_t'(lo + k);
    endfunction

endpackage

// File: rtl/ddr_burst4_cmd.sv
module ddr_burst4_cmd
    import ddr_burst4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    output logic              rise_phase,
    output logic              beat_vld,
    output logic              beat_rd,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              cmd_err
);
    localparam int HI_W = ADDR_W - 2;

    logic            phase_q;
    logic            err_q;
    logic [HI_W-1:0] hi_q;
    burst_st_t       st_q;
    logic            accept;
    logic            clash;

    assign accept = phase_q & ~load_n & ~st_q.busy;
    assign clash  = phase_q & ~load_n &  st_q.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b1;
            err_q   <= 1'b0;
            hi_q    <= '0;
            st_q    <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (clash) begin
                err_q <= 1'b1;
            end
            if (accept) begin
                st_q.busy <= 1'b1;
                st_q.rd   <= rd_nwr;
                st_q.cnt  <= beat_idx_t'(1);
                st_q.lo   <= addr[1:0];
                hi_q      <= addr[ADDR_W-1:2];
            end else if (st_q.busy) begin
                st_q.cnt <= beat_idx_t'(st_q.cnt + 1'b1);
                if (st_q.cnt == beat_idx_t'(BURST_LEN - 1)) begin
                    st_q.busy <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        beat_vld = accept | st_q.busy;
        if (accept) begin
            beat_rd   = rd_nwr;
            beat_addr = addr;
        end else begin
            beat_rd   = st_q.rd;
            beat_addr = {hi_q, wrap_lo(st_q.lo, st_q.cnt)};
        end
    end

    assign rise_phase = phase_q;
    assign cmd_err    = err_q;

    // R2: the phase flag flips on every beat after reset
    assert_phase_alt_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase_q != $past(phase_q)));

    // R3: the second beat of any burst always falls on a falling half
    assert_beat1_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.cnt == beat_idx_t'(1)) |-> !phase_q);

    // R9: once set, the error flag holds until reset
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R9: the error flag only rises after a rising-half edge inside a burst
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> ($past(phase_q) && $past(st_q.busy)));

endmodule

// File: rtl/ddr_burst4_mem.sv
module ddr_burst4_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wsel_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH  = 2 ** ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we && !wsel_n[g]) begin
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
            rd_q <= re ? store[raddr] : '0;
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/ddr_burst4_rdpipe.sv
module ddr_burst4_rdpipe #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              oe
);
    logic              s1_v, s2_v, oe_q;
    logic [ADDR_W-1:0] s1_a, s2_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            oe_q <= 1'b0;
            s1_a <= '0;
            s2_a <= '0;
        end else begin
            s1_v <= req;
            s1_a <= req_addr;
            s2_v <= s1_v;
            s2_a <= s1_a;
            oe_q <= s2_v;
        end
    end

    assign mem_re    = s2_v;
    assign mem_raddr = s2_a;
    assign oe        = oe_q;

endmodule

// File: rtl/ddr_burst4_sram.sv
module ddr_burst4_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wsel_n,
    output logic              rise_phase,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              cmd_err
);
    logic              beat_vld, beat_rd;
    logic [ADDR_W-1:0] beat_addr;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_raddr;

    ddr_burst4_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .load_n     (load_n),
        .rd_nwr     (rd_nwr),
        .addr       (addr),
        .rise_phase (rise_phase),
        .beat_vld   (beat_vld),
        .beat_rd    (beat_rd),
        .beat_addr  (beat_addr),
        .cmd_err    (cmd_err)
    );

    ddr_burst4_rdpipe #(.ADDR_W(ADDR_W)) u_rdpipe (
        .clk       (clk),
        .rst       (rst),
        .req       (beat_vld & beat_rd),
        .req_addr  (beat_addr),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .oe        (rdata_oe)
    );

    ddr_burst4_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_mem (
        .clk    (clk),
        .we     (beat_vld & ~beat_rd),
        .waddr  (beat_addr),
        .wdata  (wdata),
        .wsel_n (wsel_n),
        .re     (mem_re),
        .raddr  (mem_raddr),
        .rdata  (rdata)
    );

    // R8: the data port is quiet whenever the enable is low
    assert_oe_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !rdata_oe |-> (rdata == '0));

endmodule

// File: tb/ddr_burst4_sram_tb.sv
module ddr_burst4_sram_tb;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam int NL = 4;
    localparam int LW = DW / NL;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_n;
    logic          rd_nwr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [NL-1:0] wsel_n;
    logic          rise_phase;
    logic [DW-1:0] rdata;
    logic          rdata_oe;
    logic          cmd_err;

    always #2 clk = ~clk;

    ddr_burst4_sram #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .rd_nwr(rd_nwr), .addr(addr),
        .wdata(wdata), .wsel_n(wsel_n), .rise_phase(rise_phase),
        .rdata(rdata), .rdata_oe(rdata_oe), .cmd_err(cmd_err)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;
    logic [DW-1:0] model [2**AW];

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] pat(int a, int s);
        return (DW'(a) * DW'(36'h123457) + DW'(s) * DW'(36'h98763)) ^ DW'(36'hA5A5A5A5A);
    endfunction

    function automatic int wrap_addr(int a, int k);
        return (a & ~3) | ((a + k) & 3);
    endfunction

    task automatic idle();
        load_n = 1'b1; rd_nwr = 1'b0; addr = '0; wdata = '0; wsel_n = '1;
    endtask

    task automatic align();
        while (rise_phase !== 1'b1) @(negedge clk);
    endtask

    // Four-beat write; beat k uses mask m[4k+:4]
    task automatic wr_burst(int a, int s, logic [15:0] m);
        align();
        for (int k = 0; k < 4; k++) begin
            int ak;
            ak     = wrap_addr(a, k);
            load_n = (k == 0) ? 1'b0 : 1'b1;
            rd_nwr = 1'b0;
            addr   = AW'(a);
            wdata  = pat(ak, s);
            wsel_n = m[4*k +: 4];
            for (int i = 0; i < NL; i++)
                if (!m[4*k+i]) model[ak][i*LW +: LW] = wdata[i*LW +: LW];
            @(negedge clk);
        end
        idle();
    endtask

    task automatic rd_burst(int a, string req);
        align();
        load_n = 1'b0; rd_nwr = 1'b1; addr = AW'(a);
        @(negedge clk);
        idle();
        chk({req, " oe low beat1"}, 64'(rdata_oe), 64'd0);
        @(negedge clk);
        chk({req, " oe low beat2"}, 64'(rdata_oe), 64'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk({req, " R8 oe high"}, 64'(rdata_oe), 64'd1);
            chk({req, " R7 data"}, 64'(rdata), 64'(model[wrap_addr(a, k)]));
        end
        @(negedge clk);
        chk({req, " R8 oe low after"}, 64'(rdata_oe), 64'd0);
        chk({req, " R8 data zero after"}, 64'(rdata), 64'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic p0;
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 oe", 64'(rdata_oe), 64'd0);
        chk("R1 rdata", 64'(rdata), 64'd0);
        chk("R1 err", 64'(cmd_err), 64'd0);
        chk("R1 phase", 64'(rise_phase), 64'd1);
        rst = 1'b0;
        // R2: phase alternates
        p0 = rise_phase;
        for (int j = 1; j <= 6; j++) begin
            @(negedge clk);
            chk("R2 phase toggle", 64'(rise_phase), 64'(p0 ^ j[0]));
        end

        // R4 R5: fill whole memory with full-lane writes at offset 0
        for (int g = 0; g < 2**AW / 4; g++) wr_burst(4*g, 0, 16'h0000);
        // R7: read every group at every start offset
        for (int g = 0; g < 2**AW / 4; g++)
            for (int o = 0; o < 4; o++) rd_burst(4*g + o, "R5/R7 sweep");

        // R6: lane masks, per-beat masks vary, start offsets wrap
        for (int m = 0; m < 16; m++) begin
            logic [15:0] mv;
            for (int k = 0; k < 4; k++) mv[4*k +: 4] = 4'((m + 5*k) % 16);
            wr_burst(4*(m % 16) + (m % 4), m + 1, mv);
            rd_burst(4*(m % 16) + ((m + 1) % 4), "R6 masked");
        end

        // R3: load on a falling-half edge is ignored
        align();
        @(negedge clk);
        load_n = 1'b0; rd_nwr = 1'b0; addr = AW'(20); wdata = ~model[20]; wsel_n = '0;
        @(negedge clk);
        idle();
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk("R3 no read from falling load", 64'(rdata_oe), 64'd0);
        end
        @(negedge clk);
        load_n = 1'b0; rd_nwr = 1'b1; addr = AW'(20);
        if (rise_phase !== 1'b0) begin
            @(negedge clk);
            load_n = 1'b0; rd_nwr = 1'b1; addr = AW'(20);
        end
        @(negedge clk);
        idle();
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk("R3 falling read ignored", 64'(rdata_oe), 64'd0);
        end
        chk("R3 err untouched", 64'(cmd_err), 64'd0);
        rd_burst(20, "R3 storage unchanged");

        // R10: back-to-back reads
        align();
        load_n = 1'b0; rd_nwr = 1'b1; addr = AW'(9);
        for (int j = 1; j <= 11; j++) begin
            @(negedge clk);
            if (j == 4) begin
                load_n = 1'b0; rd_nwr = 1'b1; addr = AW'(46);
            end else begin
                idle();
            end
            if (j >= 3 && j <= 10) begin
                chk("R10 oe continuous", 64'(rdata_oe), 64'd1);
                chk("R10 data", 64'(rdata),
                    64'(model[(j <= 6) ? wrap_addr(9, j - 3) : wrap_addr(46, j - 7)]));
            end
            if (j == 11) chk("R10 oe ends", 64'(rdata_oe), 64'd0);
        end

        // R9: clashing load two beats into a write burst
        align();
        for (int k = 0; k < 4; k++) begin
            int ak;
            ak     = wrap_addr(33, k);
            load_n = (k == 0 || k == 2) ? 1'b0 : 1'b1;
            rd_nwr = (k == 2) ? 1'b1 : 1'b0;
            addr   = (k == 2) ? AW'(60) : AW'(33);
            wdata  = pat(ak, 99);
            wsel_n = '0;
            model[ak] = wdata;
            @(negedge clk);
            if (k == 2) chk("R9 err raised", 64'(cmd_err), 64'd1);
        end
        idle();
        for (int j = 0; j < 5; j++) begin
            chk("R9 dropped read gives no output", 64'(rdata_oe), 64'd0);
            @(negedge clk);
        end
        rd_burst(32, "R9 running write completed");
        chk("R9 err sticky", 64'(cmd_err), 64'd1);

        // R1: reset clears the flag
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 err cleared", 64'(cmd_err), 64'd0);
        chk("R1 phase after reset", 64'(rise_phase), 64'd1);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule